// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a processor. Each line has a fixed priority, with level 0 the most urgent. When the processor answers with an acknowledge strobe, the controller returns an 8-bit vector for the most urgent unmasked request. It also moves that request into an in-service register. That entry then holds off equal and lower levels until software retires it.

Software reaches the controller through a byte-wide port with two addresses: a command address and a data address. A start word on the command address begins a short programming sequence on the data address. That sequence sets the vector base, a stored cascade word and, optionally, a mode word that enables automatic retirement. After programming, the data address holds the mask. The command address accepts two kinds of command: register-select commands and specific end-of-interrupt commands.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the controller is unprogrammed: int_o stays low and acknowledges change nothing. The mask reads 0xFF on the data address, the in-service register is zero, and the command address returns the request register.
- R2: A command write with bit 4 set starts programming, and its bit 0 requests a mode word. The next data writes load the vector base, then the cascade word (visible on casc_o), then the mode word if it was requested. The controller becomes operational after the last of these.
- R3: When operational, a data write loads the mask, and a data read returns it. A mask bit of 1 keeps that line from raising int_o or from being acknowledged. The request bit is still latched.
- R4: Command value 0x0A selects the request register for command-address reads, and 0x0B selects the in-service register. The selection holds until it is changed.
- R5: A rising edge on a request line sets its request bit at the next clock edge. The bit clears when the request is acknowledged or while the line is low. A line held high after acknowledge does not request again.
- R6: int_o is high exactly when the controller is operational and some unmasked request is more urgent than every in-service level.
- R7: At the clock edge of an acknowledge, the most urgent unmasked request leaves the request register. vector_o becomes {base[7:3], level}. vector_o changes only on acknowledges.
- R8: Command value 0x60+n (n from 0 to 7) clears in-service bit n only.
- R9: When the mode word has bit 1 set, an acknowledge leaves no in-service bit set. Without a mode word, this automatic retirement is off.
- R10: An acknowledge with no unmasked request returns the level-7 vector and leaves the in-service register unchanged.
- R11: A new start word clears the in-service register and stops interrupts until programming completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 command address, 1 data address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_i | input | 8 | Request lines, synchronous to clk_i |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt to the processor |
| vector_o | output | 8 | Vector of the last acknowledge |
| casc_o | output | 8 | Stored cascade word |

## Verification
A wrong in-service bit shows up at int_o in the same cycle. A stale set bit holds back less urgent requests. A lost bit lets an equal-level request through, and the in-service read shows the error at once. A wrong priority choice or a wrong base appears in vector_o one edge after the acknowledge. A bad programming-sequence state shows up in one of two ways: the wrong word lands in the base or in casc_o, or int_o stays low after programming should have finished.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_IRQ = 8;
  localparam int LVL_W = $clog2(NUM_IRQ);
  localparam int BASE_W = DATA_W - LVL_W;

  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_READY
  } cfg_state_e;
endpackage

// File: rtl/pic8_find.sv
module pic8_find
  import pic8_pkg::*;
(
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o
);
  // lowest index wins
  always_comb begin
    lvl_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) lvl_o = LVL_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/pic8_req.sv
module pic8_req
  import pic8_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] ack_clr_i,
  output logic [NUM_IRQ-1:0] irr_o
);
  logic [NUM_IRQ-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_o  <= (irr_o | (irq_i & ~prev_q)) & irq_i & ~ack_clr_i;
    end
  end
endmodule

// File: rtl/pic8_cfg.sv
module pic8_cfg
  import pic8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              init_start_o,
  output logic [BASE_W-1:0] base_o,
  output logic [DATA_W-1:0] casc_o,
  output logic              aeoi_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              sel_isr_o,
  output logic              eoi_o,
  output logic [LVL_W-1:0]  eoi_lvl_o
);
  cfg_state_e state_q;
  logic       need_mode_q;
  logic       cmd_wr, data_wr, op_wr;

  assign cmd_wr       = wr_i & ~addr_i;
  assign data_wr      = wr_i & addr_i;
  assign init_start_o = cmd_wr & wdata_i[4];
  assign op_wr        = cmd_wr & ~wdata_i[4];
  assign eoi_o        = op_wr & ~wdata_i[3] & (wdata_i[7:5] == 3'b011);
  assign eoi_lvl_o    = wdata_i[LVL_W-1:0];
  assign ready_o      = (state_q == ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_UNINIT;
      need_mode_q <= 1'b0;
      base_o      <= '0;
      casc_o      <= '0;
      aeoi_o      <= 1'b0;
      mask_o      <= '1;
      sel_isr_o   <= 1'b0;
    end else begin
      if (init_start_o) begin
        state_q     <= ST_BASE;
        need_mode_q <= wdata_i[0];
        aeoi_o      <= 1'b0;
      end else if (data_wr) begin
        unique case (state_q)
          ST_BASE: begin
            base_o  <= wdata_i[DATA_W-1:LVL_W];
            state_q <= ST_CASC;
          end
          ST_CASC: begin
            casc_o  <= wdata_i;
            state_q <= need_mode_q ? ST_MODE : ST_READY;
          end
          ST_MODE: begin
            aeoi_o  <= wdata_i[1];
            state_q <= ST_READY;
          end
          ST_READY: mask_o <= wdata_i;
          default: ;
        endcase
      end
      if (op_wr && wdata_i[3] && wdata_i[1]) sel_isr_o <= wdata_i[0];
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic              inta_i,
  output logic              int_o,
  output logic [DATA_W-1:0] vector_o,
  output logic [DATA_W-1:0] casc_o
);
  logic               ready, init_start, aeoi, sel_isr, eoi;
  logic [BASE_W-1:0]  base;
  logic [DATA_W-1:0]  mask;
  logic [LVL_W-1:0]   eoi_lvl, p_lvl, s_lvl;
  logic [NUM_IRQ-1:0] irr, isr, pend, ack_clr;
  logic               p_any, s_any, ack;

  pic8_cfg u_cfg (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .ready_o(ready), .init_start_o(init_start), .base_o(base),
    .casc_o(casc_o), .aeoi_o(aeoi), .mask_o(mask),
    .sel_isr_o(sel_isr), .eoi_o(eoi), .eoi_lvl_o(eoi_lvl)
  );

  pic8_req u_req (
    .clk_i, .rst_ni, .irq_i, .ack_clr_i(ack_clr), .irr_o(irr)
  );

  assign pend = irr & ~mask;

  pic8_find u_pend_find (.vec_i(pend), .any_o(p_any), .lvl_o(p_lvl));
  pic8_find u_isr_find  (.vec_i(isr),  .any_o(s_any), .lvl_o(s_lvl));

  assign ack     = inta_i & ready;
  assign ack_clr = (ack && p_any) ? (NUM_IRQ'(1) << p_lvl) : '0;
  assign int_o   = ready & p_any & (~s_any | (p_lvl < s_lvl));
  assign rdata_o = addr_i ? mask : (sel_isr ? isr : irr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr      <= '0;
      vector_o <= '0;
    end else begin
      if (init_start) begin
        isr <= '0;
      end else begin
        logic [NUM_IRQ-1:0] nxt;
        nxt = isr;
        if (eoi) nxt[eoi_lvl] = 1'b0;
        if (ack && p_any && !aeoi) nxt[p_lvl] = 1'b1;
        isr <= nxt;
      end
      if (ack) vector_o <= {base, p_any ? p_lvl : LVL_W'(NUM_IRQ - 1)};
    end
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk
  import pic8_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               inta_i,
  input logic               int_o,
  input logic [DATA_W-1:0]  vector_o,
  input logic               ready,
  input logic [NUM_IRQ-1:0] pend,
  input logic [NUM_IRQ-1:0] isr,
  input logic               eoi,
  input logic [LVL_W-1:0]   eoi_lvl
);
  // R1
  uninit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> !int_o);

  // R6
  int_has_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (pend != '0));

  // R7
  ack_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && ready) |=> ($countones(isr & ~$past(isr)) <= 1));

  // R7
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_i |=> $stable(vector_o));

  // R8
  eoi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !(inta_i && ready)) |=> !isr[$past(eoi_lvl)]);

  // R10
  spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && ready && pend == '0 && !wr_i) |=>
      (isr == $past(isr)) && (vector_o[LVL_W-1:0] == LVL_W'(NUM_IRQ - 1)));
endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .inta_i(inta_i),
  .int_o(int_o), .vector_o(vector_o), .ready(ready), .pend(pend),
  .isr(isr), .eoi(eoi), .eoi_lvl(eoi_lvl)
);

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] irq_i = '0;
  logic       inta_i = 1'b0;
  logic       int_o;
  logic [7:0] vector_o;
  logic [7:0] casc_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pic8_ctrl dut_i (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .irq_i, .inta_i, .int_o, .vector_o, .casc_o
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ack();
    @(negedge clk_i); inta_i = 1'b1;
    @(negedge clk_i); inta_i = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk_i); irq_i = v;
    @(negedge clk_i);
  endtask

  task automatic rd_reg(input logic isr_sel, output logic [7:0] d);
    wr(1'b0, isr_sel ? 8'h0B : 8'h0A);
    rd(1'b0, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b1, d); check("R1 mask", d, 8'hFF);
    rd(1'b0, d); check("R1 irr", d, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R1 isr", d, 8'h00);
    wr(1'b0, 8'h0A);
    set_irq(8'h01);
    check("R1 int", {7'd0, int_o}, 8'h00);
    ack();
    check("R1 vec", vector_o, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    check("R2 casc", casc_o, 8'h04);
    wr(1'b1, 8'h00);
    rd(1'b1, d); check("R3 mask rd", d, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    set_irq(8'h08);
    rd_reg(1'b0, d); check("R5 set", d, 8'h08);
    check("R6 int", {7'd0, int_o}, 8'h01);
    set_irq(8'h00);
    rd(1'b0, d); check("R5 fall", d, 8'h00);
    check("R6 int low", {7'd0, int_o}, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    set_irq(8'h24);
    check("R6 int", {7'd0, int_o}, 8'h01);
    ack();
    check("R7 vec2", vector_o, 8'h22);
    rd_reg(1'b1, d); check("R7 isr", d, 8'h04);
    rd(1'b0, d); check("R4 persist", d, 8'h04);
    rd_reg(1'b0, d); check("R7 irr", d, 8'h20);
    check("R6 blocked", {7'd0, int_o}, 8'h00);
    ack();
    check("R7 vec5", vector_o, 8'h25);
    rd(1'b0, d); check("R5 no retrig", d, 8'h00);
    wr(1'b0, 8'h62);
    rd_reg(1'b1, d); check("R8 eoi2", d, 8'h20);
    wr(1'b0, 8'h65);
    rd(1'b0, d); check("R8 eoi5", d, 8'h00);
    wr(1'b0, 8'h0A);
    set_irq(8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1'b1, 8'h08);
    set_irq(8'h08);
    check("R3 masked", {7'd0, int_o}, 8'h00);
    rd(1'b0, d); check("R3 latched", d, 8'h08);
    wr(1'b1, 8'h00);
    check("R3 unmask", {7'd0, int_o}, 8'h01);
    ack();
    check("R7 vec3", vector_o, 8'h23);
    wr(1'b0, 8'h63);
    set_irq(8'h00);
  endtask

  task automatic t_spur();
    logic [7:0] d;
    ack();
    check("R10 vec", vector_o, 8'h27);
    rd_reg(1'b1, d); check("R10 isr", d, 8'h00);
    set_irq(8'h02);
    set_irq(8'h00);
    ack();
    check("R10 vanish", vector_o, 8'h27);
    rd(1'b0, d); check("R10 isr2", d, 8'h00);
    wr(1'b0, 8'h0A);
  endtask

  task automatic t_reinit_aeoi();
    logic [7:0] d;
    set_irq(8'h10);
    ack();
    check("R7 vec4", vector_o, 8'h24);
    wr(1'b0, 8'h11);
    rd_reg(1'b1, d); check("R11 isr clr", d, 8'h00);
    set_irq(8'h00);
    set_irq(8'h01);
    check("R11 quiet", {7'd0, int_o}, 8'h00);
    ack();
    check("R11 no ack", vector_o, 8'h24);
    set_irq(8'h00);
    wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h03);
    check("R2 casc2", casc_o, 8'h02);
    set_irq(8'h40);
    ack();
    check("R9 vec", vector_o, 8'h2E);
    rd(1'b0, d); check("R9 isr", d, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_no_mode();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    set_irq(8'h01);
    check("R2 ready", {7'd0, int_o}, 8'h01);
    ack();
    check("R7 vec0", vector_o, 8'h40);
    rd_reg(1'b1, d); check("R9 off", d, 8'h01);
    wr(1'b0, 8'h60);
    rd(1'b0, d); check("R8 eoi0", d, 8'h00);
    set_irq(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_init();
    t_edge();
    t_prio();
    t_mask();
    t_spur();
    t_reinit_aeoi();
    t_no_mode();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule